// File: doc/BRIEF.md
# Processor Interrupt Input Conditioner

This block sits between six asynchronous control pins of a processor core and the core's interrupt logic. Each pin is brought into the clock domain by a short flop chain, then compared with a stored copy of its last accepted level. Only a real change of level is acted on, so a pin that keeps its level never produces a second event. What an accepted change does depends on the pin: two pins are level-driven interrupt requests, one pin fires only on a falling edge, one pin gates a halt output, one pin produces a single-cycle core reset pulse, and one pin is a level-driven soft reset request.

Interrupt requests collect in a four-bit pending vector. A single combined hard-interrupt line to the core is high whenever any pending bit is set and falls only when the whole vector is empty. Software clears bits through a plain acknowledge mask input; one cycle of a nonzero mask clears the selected bits at the next clock edge. All control pins and the mask are plain signals with no handshake; the block never stalls its inputs.

Pin indices: 0 external interrupt, 1 system-management interrupt, 2 machine check, 3 checkstop, 4 hard reset, 5 soft reset. Pending bits: 0 external, 1 system management, 2 machine check, 3 soft reset.

Top module: `irq_input_cond`

## Requirements
- R1: A level change on any pin is acted on at the third rising clock edge after it appears (two synchroniser stages plus the change stage) and not before.
- R2: A pin that keeps its level produces no event; a pending bit cleared by acknowledge stays clear while its pin simply stays high.
- R3: Pins 0 and 1 are active-high levels; a rise sets pending bit 0 or 1 and a fall clears it.
- R4: Pin 2 sets pending bit 2 on a high-to-low change only; a low-to-high change leaves the pending vector unchanged.
- R5: halt_o goes high when pin 3 changes to high and low when pin 3 changes to low, and changes at no other time.
- R6: A low-to-high change on pin 4 gives a core_rst_o pulse exactly one cycle long and does not alter the pending vector; a high-to-low change gives no pulse.
- R7: Pin 5 is an active-high level; a rise sets pending bit 3 and a fall clears it.
- R8: hard_irq_o is high exactly when the pending vector is nonzero, changing in the same cycle as the vector.
- R9: A 1 in ack_mask_i clears that pending bit at the next rising edge.
- R10: When a set event and an acknowledge hit the same pending bit at the same edge, the bit ends up set.
- R11: After reset, the pending vector, hard_irq_o, halt_o and core_rst_o are all 0, and every stored pin level is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 6 | Asynchronous control pins, index as listed above |
| ack_mask_i | input | 4 | Pending-bit clear mask, synchronous |
| pend_o | output | 4 | Pending interrupt vector |
| hard_irq_o | output | 1 | Combined interrupt request to the core |
| halt_o | output | 1 | Halt request driven by the checkstop pin |
| core_rst_o | output | 1 | One-cycle core reset pulse |

## Verification
The hardest case to reach is a set event and an acknowledge landing on the same pending bit at the same edge, because the set appears only after the synchroniser delay while the acknowledge acts at once. The stimulus changes the external-interrupt pin, counts two falling edges, and then holds the acknowledge mask across exactly the third rising edge, where the change is taken. A second subtle case is an acknowledged bit whose pin stays high: the bench holds the pin for several cycles and re-drives the same level to show no fresh event appears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned PIN_N  = 6;
  localparam int unsigned PEND_W = 4;

  // pin positions
  localparam int unsigned P_EXT  = 0;
  localparam int unsigned P_SMI  = 1;
  localparam int unsigned P_MCHK = 2;
  localparam int unsigned P_STOP = 3;
  localparam int unsigned P_HRST = 4;
  localparam int unsigned P_SRST = 5;

  // pending vector positions
  localparam int unsigned B_EXT  = 0;
  localparam int unsigned B_SMI  = 1;
  localparam int unsigned B_MCHK = 2;
  localparam int unsigned B_SRST = 3;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_track.sv
module irqc_track #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] chg_o,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] held_q;

  // held level follows the input only on the cycle a change is taken
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign chg_o[i] = lvl_i[i] ^ held_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       held_q[i] <= 1'b0;
      else if (chg_o[i]) held_q[i] <= lvl_i[i];
    end
  end

  assign lvl_o = lvl_i;
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] drop_i,
  input  logic [WIDTH-1:0] ack_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] pend_next_o
);
  logic [WIDTH-1:0] pend_q;

  // set has priority over both level-drop and acknowledge
  assign pend_next_o = (pend_q & ~(drop_i | ack_i)) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_next_o;
  end

  assign pend_o = pend_q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_chk
    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> pend_q[k]);
    a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[k] && !set_i[k]) |=> !pend_q[k]);
  end
endmodule

// File: rtl/irq_input_cond.sv
module irq_input_cond
  import irqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIN_N-1:0]  pins_i,
  input  logic [PEND_W-1:0] ack_mask_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              hard_irq_o,
  output logic              halt_o,
  output logic              core_rst_o
);
  logic [PIN_N-1:0]  sync_lvl, chg, lvl;
  logic [PIN_N-1:0]  rise, fall;
  logic [PEND_W-1:0] set_v, drop_v, pend_next;
  logic              irq_q, halt_q, crst_q;

  irqc_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(sync_lvl));

  irqc_track #(.WIDTH(PIN_N)) i_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl), .chg_o(chg), .lvl_o(lvl));

  assign rise = chg & lvl;
  assign fall = chg & ~lvl;

  always_comb begin
    set_v          = '0;
    drop_v         = '0;
    set_v[B_EXT]   = rise[P_EXT];
    drop_v[B_EXT]  = fall[P_EXT];
    set_v[B_SMI]   = rise[P_SMI];
    drop_v[B_SMI]  = fall[P_SMI];
    set_v[B_MCHK]  = fall[P_MCHK];
    set_v[B_SRST]  = rise[P_SRST];
    drop_v[B_SRST] = fall[P_SRST];
  end

  irqc_pend #(.WIDTH(PEND_W)) i_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .drop_i(drop_v),
    .ack_i(ack_mask_i), .pend_o(pend_o), .pend_next_o(pend_next));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
      crst_q <= 1'b0;
    end else begin
      irq_q  <= |pend_next;
      crst_q <= rise[P_HRST];
      if (rise[P_STOP])      halt_q <= 1'b1;
      else if (fall[P_STOP]) halt_q <= 1'b0;
    end
  end

  assign hard_irq_o = irq_q;
  assign halt_o     = halt_q;
  assign core_rst_o = crst_q;

  a_r8_irq_matches_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_irq_o == (|pend_o));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> !core_rst_o);
  a_r5_halt_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(halt_o) |-> $past(chg[P_STOP]));
  a_r4_mchk_falling_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o[B_MCHK]) |-> $past(fall[P_MCHK]));
endmodule

// File: tb/test_irq_input_cond.sv
module test_irq_input_cond;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pins = '0;
  logic [3:0] ack = '0;
  logic [3:0] pend;
  logic       irq, halt, crst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [3:0] pend;
    logic       irq;
    logic       halt;
    logic       crst;
  } exp_t;
  exp_t sb[$];
  event chk_ev;

  always #4 clk = ~clk;

  irq_input_cond i_irq_input_cond (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .ack_mask_i(ack),
    .pend_o(pend), .hard_irq_o(irq), .halt_o(halt), .core_rst_o(crst));

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (pend !== e.pend || irq !== e.irq || halt !== e.halt || crst !== e.crst) begin
          errors++;
          $display("FAIL %s: got pend=%b irq=%b halt=%b rst=%b expected pend=%b irq=%b halt=%b rst=%b",
                   e.tag, pend, irq, halt, crst, e.pend, e.irq, e.halt, e.crst);
        end
      end
    end
  end

  task automatic expect_now(string tag, logic [3:0] p, logic i, logic h, logic r);
    exp_t e;
    e.tag = tag; e.pend = p; e.irq = i; e.halt = h; e.crst = r;
    sb.push_back(e);
    -> chk_ev;
    #1;
  endtask

  // change one pin and wait until the change has been taken (R1 latency)
  task automatic set_pin(int idx, logic v);
    @(negedge clk);
    pins[idx] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ack(logic [3:0] m);
    @(negedge clk);
    ack = m;
    @(negedge clk);
    ack = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R11 reset state", 4'b0000, 0, 0, 0);

    // R1: not visible after two edges, visible after three
    @(negedge clk);
    pins[0] = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R1 no early event", 4'b0000, 0, 0, 0);
    @(negedge clk);
    expect_now("R1 R3 ext rise", 4'b0001, 1, 0, 0);

    set_pin(1, 1'b1);
    expect_now("R3 smi rise", 4'b0011, 1, 0, 0);
    set_pin(1, 1'b0);
    expect_now("R3 smi fall", 4'b0001, 1, 0, 0);

    pulse_ack(4'b0001);
    expect_now("R9 ack ext", 4'b0000, 0, 0, 0);
    @(negedge clk);
    pins[0] = 1'b1;            // same level again
    repeat (4) @(negedge clk);
    expect_now("R2 held level no new event", 4'b0000, 0, 0, 0);
    set_pin(0, 1'b0);
    expect_now("R3 ext fall", 4'b0000, 0, 0, 0);

    set_pin(2, 1'b1);
    expect_now("R4 mchk rise ignored", 4'b0000, 0, 0, 0);
    set_pin(2, 1'b0);
    expect_now("R4 mchk fall sets", 4'b0100, 1, 0, 0);

    set_pin(5, 1'b1);
    expect_now("R7 soft reset rise", 4'b1100, 1, 0, 0);
    pulse_ack(4'b0100);
    expect_now("R8 R9 irq held by other bit", 4'b1000, 1, 0, 0);
    set_pin(5, 1'b0);
    expect_now("R7 R8 soft reset fall", 4'b0000, 0, 0, 0);

    set_pin(3, 1'b1);
    expect_now("R5 halt set", 4'b0000, 0, 1, 0);
    set_pin(3, 1'b0);
    expect_now("R5 halt clear", 4'b0000, 0, 0, 0);

    set_pin(4, 1'b1);
    expect_now("R6 reset pulse", 4'b0000, 0, 0, 1);
    @(negedge clk);
    expect_now("R6 pulse one cycle", 4'b0000, 0, 0, 0);
    set_pin(4, 1'b0);
    expect_now("R6 no pulse on fall", 4'b0000, 0, 0, 0);

    // R10: acknowledge held across the edge that takes the set event
    @(negedge clk);
    pins[0] = 1'b1;
    repeat (2) @(negedge clk);
    ack = 4'b0001;
    @(negedge clk);
    ack = '0;
    expect_now("R10 set wins over ack", 4'b0001, 1, 0, 0);
    pulse_ack(4'b0001);
    expect_now("R9 ack after collision", 4'b0000, 0, 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule